// File: doc/BRIEF.md
# Indirect SRAM Byte Access Port

This block lets a host reach an external asynchronous byte-wide SRAM one byte at a time through a single 32-bit command word. The host writes the whole word in one cycle. The word names the target byte address, the transfer direction, the byte to store, and one of four banks. It must also carry a fixed validation code. The block accepts the word, raises a busy flag in the same register, and runs one SRAM cycle on the chosen bank. That cycle has a setup phase, a programmable access phase and a hold phase. When the cycle ends, the block clears busy.

On a read, the byte fetched from the SRAM replaces the data field of the register, so the host gets its result by reading the same word it wrote. The SRAM data pins are split into an output byte, an input byte and a drive-enable. A pad ring or a bench turns these into a shared bus.

Top module: `sram_cmd_port`

## Requirements
- R1: While reset is high and in the cycle after it, the register reads 0, every chip enable is high (inactive), write-enable and output-enable are high and the data drive-enable is 0.
- R2: The command word layout is as follows. Bits 14:0 hold the byte address. Bit 15 is the direction (1 read, 0 write). Bits 23:16 hold the data byte. Bits 27:24 hold the code. Bits 29:28 hold the bank. Bit 31 is busy and bit 30 always reads 0. An accepted word appears in the register, with busy set, on the cycle after it is written.
- R3: A word whose bits 27:24 are not 4 is ignored. It causes no SRAM activity and leaves the register unchanged.
- R4: Busy stays set for exactly WAIT_CYC+2 cycles per accepted command. While busy is clear, no chip enable is active.
- R5: A write holds write-enable low for exactly WAIT_CYC cycles. Write-enable falls one cycle after the chip enable goes active and rises one cycle before it goes inactive. During that time the address and the data byte are driven.
- R6: A read holds output-enable low for the whole access. When busy clears, bits 23:16 hold the byte the SRAM returned, and all other fields keep their command values.
- R7: Only the chip enable whose index equals bits 29:28 goes low, and it stays low for the whole busy period.
- R8: A word written while busy is set is dropped. It does not change the address, bank, direction or data of the access in progress.
- R9: The data drive-enable is high only while a write access is busy. During reads and while idle it is low.
- R10: The SRAM address does not change while busy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 32 | Command word written by the host |
| cmd_rdata | output | 32 | Register readback: command, status and read data |
| sram_addr | output | 15 | SRAM byte address |
| sram_dq_o | output | 8 | Byte driven toward the SRAM |
| sram_dq_oe | output | 1 | Drive-enable for the data byte (0 = high impedance) |
| sram_dq_i | input | 8 | Byte returned by the SRAM |
| sram_ce_n | output | 4 | Active-low chip enable, one per bank |
| sram_oe_n | output | 1 | Active-low SRAM output-enable |
| sram_we_n | output | 1 | Active-low SRAM write-enable |

## Verification
The bench issues commands with the wrong code. A design that checked too few code bits would start an SRAM cycle or overwrite the register. It also writes a second command one cycle after the first. A design without the busy guard would retarget the access in flight, leaving the first byte unwritten and the second one written. Writes and readbacks cover every bank and both ends of the address range, so a bank-decode or address-width slip returns the wrong byte. Counting write-enable low cycles per access catches a strobe that is off by one, or one that spills outside the chip-enable window.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

    localparam int ADDR_W    = 15;
    localparam int DATA_W    = 8;
    localparam int BANK_W    = 2;
    localparam int CODE_W    = 4;
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int WORD_W    = 32;
    localparam logic [CODE_W-1:0] VALID_CODE = CODE_W'(4);

    // Field order is bit-exact: the host packs the word this way.
    typedef struct packed {
        logic              busy;
        logic              rsvd;
        logic [BANK_W-1:0] bank;
        logic [CODE_W-1:0] code;
        logic [DATA_W-1:0] data;
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } cmd_word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACCESS,
        ST_HOLD
    } seq_state_t;

    function automatic logic cmd_is_valid(cmd_word_t c);
        return c.code == VALID_CODE;
    endfunction

endpackage

// File: rtl/sram_cmd_reg.sv
module sram_cmd_reg
    import sram_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  cmd_word_t         wr_word,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              accept,
    output cmd_word_t         cur
);

    cmd_word_t nxt;

    assign accept = wr_en && !cur.busy && cmd_is_valid(wr_word);

    always_comb begin
        nxt = cur;
        if (accept) begin
            nxt      = wr_word;
            nxt.busy = 1'b1;
            nxt.rsvd = 1'b0;
        end else if (done) begin
            nxt.busy = 1'b0;
            if (cur.rd) begin
                nxt.data = rd_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_port_pkg::*;
#(
    parameter int WAIT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_rd,
    input  logic [DATA_W-1:0] dq_i,
    output seq_state_t        state,
    output logic              done,
    output logic [DATA_W-1:0] rd_byte
);

    localparam int CNT_W = $clog2(WAIT_CYC + 1);

    logic [CNT_W-1:0] cnt;

    assign done = (state == ST_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rd_byte <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cnt   <= CNT_W'(WAIT_CYC - 1);
                    state <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    if (cnt == '0) begin
                        state <= ST_HOLD;
                        if (is_rd) begin
                            rd_byte <= dq_i;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sram_bank_dec.sv
module sram_bank_dec #(
    parameter int NUM_BANKS = 4
) (
    input  logic                         active,
    input  logic [$clog2(NUM_BANKS)-1:0] bank,
    output logic [NUM_BANKS-1:0]         ce_n
);

    localparam int SEL_W = $clog2(NUM_BANKS);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_ce
        assign ce_n[g] = !(active && (bank == SEL_W'(g)));
    end

endmodule

// File: rtl/sram_cmd_port.sv
module sram_cmd_port
    import sram_port_pkg::*;
#(
    parameter int WAIT_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_wr,
    input  logic [WORD_W-1:0]    cmd_wdata,
    output logic [WORD_W-1:0]    cmd_rdata,
    output logic [ADDR_W-1:0]    sram_addr,
    output logic [DATA_W-1:0]    sram_dq_o,
    output logic                 sram_dq_oe,
    input  logic [DATA_W-1:0]    sram_dq_i,
    output logic [NUM_BANKS-1:0] sram_ce_n,
    output logic                 sram_oe_n,
    output logic                 sram_we_n
);

    cmd_word_t         cur;
    logic              accept;
    logic              done;
    logic [DATA_W-1:0] rd_byte;
    seq_state_t        state;
    logic              active;

    sram_cmd_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cmd_wr),
        .wr_word (cmd_word_t'(cmd_wdata)),
        .done    (done),
        .rd_byte (rd_byte),
        .accept  (accept),
        .cur     (cur)
    );

    sram_seq #(.WAIT_CYC(WAIT_CYC)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .is_rd   (cur.rd),
        .dq_i    (sram_dq_i),
        .state   (state),
        .done    (done),
        .rd_byte (rd_byte)
    );

    assign active = (state != ST_IDLE);

    sram_bank_dec #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .active (active),
        .bank   (cur.bank),
        .ce_n   (sram_ce_n)
    );

    assign cmd_rdata  = cur;
    assign sram_addr  = cur.addr;
    assign sram_dq_o  = cur.data;
    assign sram_dq_oe = active && !cur.rd;
    assign sram_oe_n  = !(active && cur.rd);
    assign sram_we_n  = !((state == ST_ACCESS) && !cur.rd);

endmodule

// File: rtl/sram_port_chk.sv
module sram_port_chk
    import sram_port_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_wr,
    input logic [WORD_W-1:0]    cmd_rdata,
    input logic [ADDR_W-1:0]    sram_addr,
    input logic                 sram_dq_oe,
    input logic [NUM_BANKS-1:0] sram_ce_n,
    input logic                 sram_we_n
);

    AST_CE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~sram_ce_n)); // R7

    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> ((~sram_ce_n) != '0) && sram_dq_oe); // R5

    AST_WE_AFTER_CE: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> ($past(sram_ce_n) == sram_ce_n)); // R5

    AST_WE_RISE_INSIDE: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> ((~sram_ce_n) != '0)); // R5

    AST_DQ_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> cmd_rdata[31] && !cmd_rdata[15]); // R9

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        cmd_rdata[31] && $past(cmd_rdata[31]) |-> $stable(sram_addr)); // R10

    AST_BUSY_DROP: assert property (@(posedge clk) disable iff (rst)
        cmd_rdata[31] && cmd_wr |=>
            (cmd_rdata[15:0] == $past(cmd_rdata[15:0])) &&
            (cmd_rdata[29:24] == $past(cmd_rdata[29:24]))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !cmd_rdata[31] |-> (&sram_ce_n) && sram_we_n && !sram_dq_oe); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        cmd_rdata[30] == 1'b0); // R2

endmodule

bind sram_cmd_port sram_port_chk u_chk (.*);

// File: tb/tb_sram_cmd_port.sv
`timescale 1ns/1ps
module tb_sram_cmd_port;

    localparam int WAIT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic [14:0] sram_addr;
    logic [7:0]  sram_dq_o;
    logic        sram_dq_oe;
    logic [7:0]  sram_dq_i;
    logic [3:0]  sram_ce_n;
    logic        sram_oe_n;
    logic        sram_we_n;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sram_cmd_port #(.WAIT_CYC(WAIT)) dut (.*);

    // ---------- SRAM model driven only by the bus ----------
    byte unsigned sram_mem[int];
    byte unsigned ref_mem[int];

    function automatic byte unsigned blank(int key);
        return byte'(key[7:0] ^ 8'hA5);
    endfunction

    function automatic int ce_bank(logic [3:0] ce);
        int b = -1;
        for (int i = 0; i < 4; i++) if (!ce[i]) b = i;
        return b;
    endfunction

    always_comb begin
        int b;
        int k;
        b = ce_bank(sram_ce_n);
        k = (b << 15) | int'(sram_addr);
        sram_dq_i = 8'h00;
        if (b >= 0 && !sram_oe_n) begin
            sram_dq_i = sram_mem.exists(k) ? sram_mem[k] : blank(k);
        end
    end

    always @(posedge clk) begin
        if (!sram_we_n && sram_dq_oe && ce_bank(sram_ce_n) >= 0) begin
            sram_mem[(ce_bank(sram_ce_n) << 15) | int'(sram_addr)] = sram_dq_o;
        end
    end

    // ---------- behavioural reference of the register ----------
    logic [31:0] exp_reg;
    int          exp_cnt;

    always @(posedge clk) begin
        if (rst) begin
            exp_reg = '0;
            exp_cnt = 0;
        end else if (exp_cnt > 0) begin
            exp_cnt--;
            if (exp_cnt == 0) begin
                int k;
                k = (int'(exp_reg[29:28]) << 15) | int'(exp_reg[14:0]);
                exp_reg[31] = 1'b0;
                if (exp_reg[15]) exp_reg[23:16] = ref_mem.exists(k) ? ref_mem[k] : blank(k);
            end
        end else if (cmd_wr && cmd_wdata[27:24] == 4'd4) begin
            exp_reg     = cmd_wdata;
            exp_reg[31] = 1'b1;
            exp_reg[30] = 1'b0;
            exp_cnt     = WAIT + 2;
            if (!cmd_wdata[15]) ref_mem[(int'(cmd_wdata[29:28]) << 15) | int'(cmd_wdata[14:0])] = cmd_wdata[23:16];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------- per-cycle comparison, away from the active edge ----------
    int we_cnt    = 0;
    bit prev_busy = 0;
    bit prev_rd   = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(cmd_rdata[31] == exp_reg[31], "R4 busy", {31'd0, cmd_rdata[31]}, {31'd0, exp_reg[31]});
            chk(cmd_rdata[30:0] == exp_reg[30:0], "R2/R6 register", cmd_rdata, exp_reg);
            chk(sram_ce_n == (exp_reg[31] ? ~(4'b1 << exp_reg[29:28]) : 4'hF), "R7 chip enables",
                {28'd0, sram_ce_n}, {28'd0, exp_reg[31] ? ~(4'b1 << exp_reg[29:28]) : 4'hF});
            chk(sram_dq_oe == (exp_reg[31] && !exp_reg[15]), "R9 drive enable",
                {31'd0, sram_dq_oe}, {31'd0, exp_reg[31] && !exp_reg[15]});
            if (exp_reg[31]) begin
                chk(sram_addr == exp_reg[14:0], "R10 address", {17'd0, sram_addr}, {17'd0, exp_reg[14:0]});
                chk(sram_oe_n == !exp_reg[15], "R6 output enable", {31'd0, sram_oe_n}, {31'd0, !exp_reg[15]});
            end
            if (!sram_we_n) begin
                we_cnt++;
                chk(sram_dq_o == exp_reg[23:16], "R5 write data", {24'd0, sram_dq_o}, {24'd0, exp_reg[23:16]});
            end
            if (prev_busy && !exp_reg[31]) begin
                chk(we_cnt == (prev_rd ? 0 : WAIT), "R5 we low cycles", we_cnt, prev_rd ? 0 : WAIT);
                we_cnt = 0;
            end
            prev_busy = exp_reg[31];
            prev_rd   = exp_reg[15];
        end
    end

    // ---------- stimulus helpers ----------
    function automatic logic [31:0] mk(input int bank, input bit rd, input logic [7:0] d,
                                       input logic [14:0] a, input logic [3:0] code);
        return {2'b00, 2'(bank), code, d, rd, a};
    endfunction

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        cmd_wr    = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr    = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100; i++) begin
            if (!cmd_rdata[31]) break;
            @(negedge clk);
        end
    endtask

    task automatic do_read(input int bank, input logic [14:0] a, input logic [7:0] exp, input string tag);
        send(mk(bank, 1'b1, 8'h00, a, 4'd4));
        wait_idle();
        chk(cmd_rdata[23:16] == exp, tag, {24'd0, cmd_rdata[23:16]}, {24'd0, exp});
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R4 watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(cmd_rdata == 32'd0, "R1 reset register", cmd_rdata, 32'd0);
        chk(sram_ce_n == 4'hF && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 reset bus",
            {28'd0, sram_ce_n}, 32'hF);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_rdata == 32'd0, "R1 after reset", cmd_rdata, 32'd0);

        // R5 R7: writes across all banks and address extremes
        send(mk(0, 1'b0, 8'h11, 15'h0000, 4'd4)); wait_idle();
        send(mk(1, 1'b0, 8'h22, 15'h7FFF, 4'd4)); wait_idle();
        send(mk(2, 1'b0, 8'h33, 15'h1234, 4'd4)); wait_idle();
        send(mk(3, 1'b0, 8'h44, 15'h0555, 4'd4)); wait_idle();

        // R6: readback from each bank
        do_read(0, 15'h0000, 8'h11, "R6 read bank0");
        do_read(1, 15'h7FFF, 8'h22, "R6 read bank1 top");
        do_read(2, 15'h1234, 8'h33, "R6 read bank2");
        do_read(3, 15'h0555, 8'h44, "R6 read bank3");
        do_read(1, 15'h0000, 8'hA5, "R7 other bank untouched");

        // R3: wrong code ignored
        snap = cmd_rdata;
        send(mk(0, 1'b0, 8'hEE, 15'h0000, 4'd5));
        send(mk(0, 1'b0, 8'hEE, 15'h0000, 4'd12));
        repeat (WAIT + 4) @(negedge clk);
        chk(cmd_rdata == snap, "R3 register unchanged", cmd_rdata, snap);
        chk(sram_ce_n == 4'hF, "R3 no SRAM cycle", {28'd0, sram_ce_n}, 32'hF);
        do_read(0, 15'h0000, 8'h11, "R3 byte kept");

        // R8: command while busy dropped
        send(mk(2, 1'b0, 8'h66, 15'h0005, 4'd4));
        send(mk(2, 1'b0, 8'h77, 15'h0006, 4'd4));
        wait_idle();
        do_read(2, 15'h0006, 8'hA3, "R8 dropped write absent");
        do_read(2, 15'h0005, 8'h66, "R8 first write intact");

        // R4: back-to-back command right as busy clears
        send(mk(3, 1'b0, 8'h5C, 15'h2AAA, 4'd4));
        wait_idle();
        send(mk(3, 1'b1, 8'h00, 15'h2AAA, 4'd4));
        chk(cmd_rdata[31] == 1'b1, "R4 busy after accept", cmd_rdata, exp_reg);
        wait_idle();
        chk(cmd_rdata[23:16] == 8'h5C, "R6 read after write", {24'd0, cmd_rdata[23:16]}, 32'h5C);

        repeat (4) @(negedge clk);
        report();
        $finish;
    end

endmodule